// File: doc/BRIEF.md
# Pixel Output Formatter with Blanking

This block is the last digital stage behind a pipelined pixel converter. Raw samples enter one per clock and pass through a fixed-length delay line. At the tail of that line the word is conditioned before it leaves the block. A preblank strobe can replace it with zero or with the black clamp level. A clamp strobe cancels that blanking, so that optical-black pixels always reach the clamp loop intact. The word can then be recoded from straight binary to Gray code.

The conditioned word is either captured in an output register or passed straight through. Capture happens on edges where the data-clock input sits at its programmed active level. A separate output-enable drives the three-state pad control. The preblank and clamp strobes and all configuration bits act at output time and are not delayed through the line. Timing generators can therefore place the strobes against the pixels as they leave the block.

Top module: `pix_out_fmt`

## Requirements
- R1: While `rst_n` is low, the delay line and the output register clear, so `pix_out` reads 0 in registered mode.
- R2: In registered mode (`cfg_transparent`=0) with the data clock held active, a sample present on `raw_pix` at rising edge n appears on `pix_out` just after edge n+LATENCY-1. That is LATENCY edges counting n as the first, 10 by default.
- R3: In transparent mode (`cfg_transparent`=1), the same sample appears one edge earlier, just after edge n+LATENCY-2. In this mode `pix_out` follows the strobes and configuration with no further edge.
- R4: When preblank is active and the clamp strobe is low with `cfg_blank_to_clamp`=0, the word at the tail is replaced by 0.
- R5: When preblank is active and the clamp strobe is low with `cfg_blank_to_clamp`=1, the word is replaced by `clamp_level` zero-extended to the data width.
- R6: When `clamp_strobe` is high (active high), blanking is not applied and the tail pixel passes unchanged, whatever the preblank strobe does.
- R7: With `cfg_gray`=1, the output is g = b ^ (b >> 1) of the word after blanking. With `cfg_gray`=0, it is the word itself in straight binary.
- R8: In registered mode, the output register loads only on edges at which `dclk_lvl` equals `cfg_dclk_pol`. On every other edge `pix_out` holds.
- R9: `out_en` is 1 when `cfg_hiz`=0 and 0 when `cfg_hiz`=1. The value on `pix_out` is not changed by `cfg_hiz`.
- R10: Preblank is active when `blank_strobe` equals `cfg_blank_pol`, so a polarity of 1 means active high and 0 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the delay line advances on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_pix | input | DATA_W | Converter sample, one per clock |
| dclk_lvl | input | 1 | Data-clock level; enables output capture when at its active level |
| blank_strobe | input | 1 | Preblank strobe, polarity set by `cfg_blank_pol` |
| clamp_strobe | input | 1 | Optical-black clamp strobe, active high; overrides preblank |
| clamp_level | input | CLAMP_W | Black clamp level used as the blank value |
| cfg_blank_to_clamp | input | 1 | Blank value: 0 gives zero, 1 gives the clamp level |
| cfg_gray | input | 1 | Output coding: 0 gives binary, 1 gives Gray |
| cfg_transparent | input | 1 | 0 gives registered output, 1 gives a transparent path |
| cfg_hiz | input | 1 | 1 drops the output-enable |
| cfg_blank_pol | input | 1 | Active level of `blank_strobe` |
| cfg_dclk_pol | input | 1 | Active level of `dclk_lvl` |
| pix_out | output | DATA_W | Formatted pixel word |
| out_en | output | 1 | Output-enable for the three-state data pads |

## Verification
The bound checker watches the conditioning logic on every cycle. It checks that blanking produces zero or the clamp level, that a clamp strobe lets the tail pixel through, and that Gray coding matches the tail word. It also checks that the output register holds on every edge where the data clock is inactive. The fixed latency in both output modes, the reset value and the output-enable are shown only by the bench's scenarios. So is the ordering of blanking ahead of coding. The bench streams a ramp of distinct samples through the delay line and counts edges to the expected arrival.

// File: rtl/pof_pkg.sv
package pof_pkg;

   typedef enum logic {
      BLANK_TO_ZERO  = 1'b0,
      BLANK_TO_CLAMP = 1'b1
   } blank_sel_e;

   typedef struct packed {
      blank_sel_e blank_sel;
      logic       gray_en;
      logic       transparent;
      logic       hiz;
      logic       blank_pol;
      logic       dclk_pol;
   } fmt_cfg_t;

endpackage

// File: rtl/pof_delay_line.sv
module pof_delay_line #(
   parameter int W     = 12,
   parameter int DEPTH = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pof_delay_line: DEPTH must be at least 1");
      end
      if (W < 2) begin : g_bad_width
         $error("pof_delay_line: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stage[i] <= '0;
               else        stage[i] <= d;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) stage[i] <= '0;
               else        stage[i] <= stage[i-1];
            end
         end
      end
   endgenerate

   assign q = stage[DEPTH-1];
endmodule

// File: rtl/pof_blank_sel.sv
module pof_blank_sel
   import pof_pkg::*;
#(
   parameter int W  = 12,
   parameter int CW = 8
) (
   input  logic [W-1:0]  pix,
   input  logic          blank_act,
   input  logic          clamp_act,
   input  blank_sel_e    sel,
   input  logic [CW-1:0] clamp_level,
   output logic [W-1:0]  q
);
   generate
      if (CW > W) begin : g_bad_cw
         $error("pof_blank_sel: clamp width exceeds data width");
      end
   endgenerate

   logic [W-1:0] clamp_ext;
   logic [W-1:0] fill;

   generate
      if (CW == W) begin : g_same
         assign clamp_ext = clamp_level;
      end else begin : g_pad
         assign clamp_ext = {{(W-CW){1'b0}}, clamp_level};
      end
   endgenerate

   always_comb begin
      fill = (sel == BLANK_TO_CLAMP) ? clamp_ext : '0;
      // clamp strobe wins over preblank
      if (blank_act && !clamp_act) q = fill;
      else                         q = pix;
   end
endmodule

// File: rtl/pof_coder.sv
module pof_coder #(
   parameter int W = 12
) (
   input  logic [W-1:0] b,
   input  logic         gray_en,
   output logic [W-1:0] q
);
   logic [W-1:0] g;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == W-1) begin : g_msb
            assign g[i] = b[i];
         end else begin : g_low
            assign g[i] = b[i] ^ b[i+1];
         end
      end
   endgenerate

   assign q = gray_en ? g : b;
endmodule

// File: rtl/pof_out_stage.sv
module pof_out_stage #(
   parameter int W          = 12,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic         load,
   input  logic         bypass,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n)    held <= '0;
      else if (load) held <= d;
   end

   generate
      if (HAS_BYPASS) begin : g_bypass
         assign q = bypass ? d : held;
      end else begin : g_reg_only
         logic unused_bypass;
         assign unused_bypass = bypass;
         assign q = held;
      end
   endgenerate
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
   import pof_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int CLAMP_W = 8,
   parameter int LATENCY = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  raw_pix,
   input  logic               dclk_lvl,
   input  logic               blank_strobe,
   input  logic               clamp_strobe,
   input  logic [CLAMP_W-1:0] clamp_level,
   input  logic               cfg_blank_to_clamp,
   input  logic               cfg_gray,
   input  logic               cfg_transparent,
   input  logic               cfg_hiz,
   input  logic               cfg_blank_pol,
   input  logic               cfg_dclk_pol,
   output logic [DATA_W-1:0]  pix_out,
   output logic               out_en
);
   localparam int PIPE_DEPTH = LATENCY - 1;

   generate
      if (LATENCY < 2) begin : g_bad_latency
         $error("pix_out_fmt: LATENCY must be at least 2");
      end
   endgenerate

   fmt_cfg_t          cfg;
   logic [DATA_W-1:0] tail_pix;
   logic [DATA_W-1:0] blanked;
   logic [DATA_W-1:0] coded;
   logic              blank_act;
   logic              cap_en;

   always_comb begin
      cfg.blank_sel   = blank_sel_e'(cfg_blank_to_clamp);
      cfg.gray_en     = cfg_gray;
      cfg.transparent = cfg_transparent;
      cfg.hiz         = cfg_hiz;
      cfg.blank_pol   = cfg_blank_pol;
      cfg.dclk_pol    = cfg_dclk_pol;
   end

   assign blank_act = (blank_strobe == cfg.blank_pol);
   assign cap_en    = (dclk_lvl == cfg.dclk_pol);

   pof_delay_line #(.W(DATA_W), .DEPTH(PIPE_DEPTH)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pix),
      .q     (tail_pix)
   );

   pof_blank_sel #(.W(DATA_W), .CW(CLAMP_W)) u_blank (
      .pix         (tail_pix),
      .blank_act   (blank_act),
      .clamp_act   (clamp_strobe),
      .sel         (cfg.blank_sel),
      .clamp_level (clamp_level),
      .q           (blanked)
   );

   pof_coder #(.W(DATA_W)) u_code (
      .b       (blanked),
      .gray_en (cfg.gray_en),
      .q       (coded)
   );

   pof_out_stage #(.W(DATA_W), .HAS_BYPASS(1'b1)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (coded),
      .load   (cap_en),
      .bypass (cfg.transparent),
      .q      (pix_out)
   );

   assign out_en = !cfg.hiz;
endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
   parameter int DATA_W  = 12,
   parameter int CLAMP_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dclk_lvl,
   input logic               blank_strobe,
   input logic               clamp_strobe,
   input logic [CLAMP_W-1:0] clamp_level,
   input logic               cfg_blank_to_clamp,
   input logic               cfg_gray,
   input logic               cfg_transparent,
   input logic               cfg_blank_pol,
   input logic               cfg_dclk_pol,
   input logic [DATA_W-1:0]  tail_pix,
   input logic [DATA_W-1:0]  pix_out
);
   logic blanking;
   assign blanking = (blank_strobe == cfg_blank_pol) && !clamp_strobe;

   // R4
   blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_transparent && blanking && !cfg_blank_to_clamp) |-> (pix_out == '0));

   // R5
   blank_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_transparent && blanking && cfg_blank_to_clamp && !cfg_gray)
      |-> (pix_out == DATA_W'(clamp_level)));

   // R6
   clamp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_transparent && clamp_strobe && !cfg_gray) |-> (pix_out == tail_pix));

   // R7
   gray_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_transparent && !blanking && cfg_gray)
      |-> (pix_out == (tail_pix ^ (tail_pix >> 1))));

   // R8
   dclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_transparent && !$past(cfg_transparent)
       && ($past(dclk_lvl) != $past(cfg_dclk_pol))) |-> $stable(pix_out));
endmodule

bind pix_out_fmt pof_checker #(.DATA_W(DATA_W), .CLAMP_W(CLAMP_W)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .dclk_lvl           (dclk_lvl),
   .blank_strobe       (blank_strobe),
   .clamp_strobe       (clamp_strobe),
   .clamp_level        (clamp_level),
   .cfg_blank_to_clamp (cfg_blank_to_clamp),
   .cfg_gray           (cfg_gray),
   .cfg_transparent    (cfg_transparent),
   .cfg_blank_pol      (cfg_blank_pol),
   .cfg_dclk_pol       (cfg_dclk_pol),
   .tail_pix           (tail_pix),
   .pix_out            (pix_out)
);

// File: tb/pix_out_fmt_test.sv
`timescale 1ns/1ps
module pix_out_fmt_test;
   localparam int W   = 12;
   localparam int CW  = 8;
   localparam int LAT = 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [W-1:0]  raw_pix;
   logic          dclk_lvl;
   logic          blank_strobe;
   logic          clamp_strobe;
   logic [CW-1:0] clamp_level;
   logic          cfg_blank_to_clamp;
   logic          cfg_gray;
   logic          cfg_transparent;
   logic          cfg_hiz;
   logic          cfg_blank_pol;
   logic          cfg_dclk_pol;
   logic [W-1:0]  pix_out;
   logic          out_en;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   pix_out_fmt #(.DATA_W(W), .CLAMP_W(CW), .LATENCY(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .raw_pix(raw_pix), .dclk_lvl(dclk_lvl),
      .blank_strobe(blank_strobe), .clamp_strobe(clamp_strobe),
      .clamp_level(clamp_level), .cfg_blank_to_clamp(cfg_blank_to_clamp),
      .cfg_gray(cfg_gray), .cfg_transparent(cfg_transparent),
      .cfg_hiz(cfg_hiz), .cfg_blank_pol(cfg_blank_pol),
      .cfg_dclk_pol(cfg_dclk_pol), .pix_out(pix_out), .out_en(out_en)
   );

   function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [W-1:0] ramp(input int c);
      return W'(12'h100 + c * 37);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_strobes();
      blank_strobe = ~cfg_blank_pol;
      clamp_strobe = 1'b0;
   endtask

   task automatic fill(input logic [W-1:0] v);
      raw_pix = v;
      repeat (LAT + 1) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      raw_pix = 12'hFFF;
      repeat (3) @(negedge clk);
      check("R1 reset output", pix_out, '0);
      check("R9 enable with hiz=0", W'(out_en), W'(1));
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_latency(input logic transp);
      int shift;
      cfg_transparent = transp;
      idle_strobes();
      shift = transp ? LAT - 1 : LAT;
      for (int c = 0; c < 30; c++) begin
         if (c >= shift)
            check(transp ? "R3 transparent latency" : "R2 registered latency",
                  pix_out, ramp(c - shift));
         raw_pix = ramp(c);
         @(negedge clk);
      end
   endtask

   task automatic t_blank_zero();
      cfg_transparent = 1'b0;
      cfg_blank_pol = 1'b1;
      idle_strobes();
      fill(12'h7A3);
      check("R4 pass before blank", pix_out, 12'h7A3);
      cfg_blank_to_clamp = 1'b0;
      blank_strobe = 1'b1;
      @(negedge clk);
      check("R4 blank to zero", pix_out, '0);
      idle_strobes();
      @(negedge clk);
   endtask

   task automatic t_blank_pol();
      cfg_transparent = 1'b0;
      cfg_blank_pol = 1'b0;
      cfg_blank_to_clamp = 1'b0;
      blank_strobe = 1'b1;
      clamp_strobe = 1'b0;
      fill(12'h3C5);
      check("R10 high strobe ignored when active low", pix_out, 12'h3C5);
      blank_strobe = 1'b0;
      @(negedge clk);
      check("R10 low strobe blanks when active low", pix_out, '0);
      cfg_blank_pol = 1'b1;
      idle_strobes();
      @(negedge clk);
   endtask

   task automatic t_blank_clamp();
      cfg_transparent = 1'b0;
      cfg_blank_pol = 1'b1;
      cfg_blank_to_clamp = 1'b1;
      clamp_level = 8'hA5;
      idle_strobes();
      fill(12'hE01);
      blank_strobe = 1'b1;
      @(negedge clk);
      check("R5 blank to clamp level", pix_out, 12'h0A5);
      idle_strobes();
      @(negedge clk);
   endtask

   task automatic t_override();
      cfg_transparent = 1'b1;
      cfg_blank_pol = 1'b1;
      cfg_blank_to_clamp = 1'b1;
      blank_strobe = 1'b1;
      clamp_strobe = 1'b1;
      fill(12'h5D9);
      check("R6 clamp overrides blank (clamp sel)", pix_out, 12'h5D9);
      cfg_blank_to_clamp = 1'b0;
      #1;
      check("R6 clamp overrides blank (zero sel)", pix_out, 12'h5D9);
      clamp_strobe = 1'b0;
      #1;
      check("R3 transparent follows strobe", pix_out, '0);
      idle_strobes();
      @(negedge clk);
   endtask

   task automatic t_gray();
      cfg_transparent = 1'b0;
      cfg_gray = 1'b1;
      idle_strobes();
      fill(12'hB3C);
      check("R7 gray coding", pix_out, 12'hEA2);
      cfg_blank_to_clamp = 1'b1;
      clamp_level = 8'hA5;
      blank_strobe = 1'b1;
      @(negedge clk);
      check("R7 gray after blank", pix_out, to_gray(12'h0A5));
      cfg_gray = 1'b0;
      idle_strobes();
      @(negedge clk);
      check("R7 binary restored", pix_out, 12'hB3C);
   endtask

   task automatic t_dclk();
      cfg_transparent = 1'b0;
      cfg_dclk_pol = 1'b1;
      dclk_lvl = 1'b1;
      idle_strobes();
      fill(12'h111);
      check("R8 load with active high", pix_out, 12'h111);
      dclk_lvl = 1'b0;
      fill(12'h222);
      check("R8 hold while inactive", pix_out, 12'h111);
      dclk_lvl = 1'b1;
      @(negedge clk);
      check("R8 load on return", pix_out, 12'h222);
      cfg_dclk_pol = 1'b0;
      fill(12'h333);
      check("R8 hold when polarity inverted", pix_out, 12'h222);
      dclk_lvl = 1'b0;
      @(negedge clk);
      check("R8 load with active low", pix_out, 12'h333);
      cfg_dclk_pol = 1'b1;
      dclk_lvl = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_hiz();
      cfg_transparent = 1'b0;
      idle_strobes();
      fill(12'h9F4);
      cfg_hiz = 1'b1;
      @(negedge clk);
      check("R9 enable dropped", W'(out_en), W'(0));
      check("R9 data unchanged", pix_out, 12'h9F4);
      cfg_hiz = 1'b0;
      #1;
      check("R9 enable restored", W'(out_en), W'(1));
   endtask

   initial begin
      rst_n = 1'b0;
      raw_pix = '0;
      dclk_lvl = 1'b1;
      cfg_blank_pol = 1'b1;
      blank_strobe = 1'b0;
      clamp_strobe = 1'b0;
      clamp_level = 8'h80;
      cfg_blank_to_clamp = 1'b0;
      cfg_gray = 1'b0;
      cfg_transparent = 1'b0;
      cfg_hiz = 1'b0;
      cfg_dclk_pol = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency(1'b0);
      t_latency(1'b1);
      t_blank_zero();
      t_blank_pol();
      t_blank_clamp();
      t_override();
      t_gray();
      t_dclk();
      t_hiz();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule